// File: doc/BRIEF.md
# IrDA SIR receive pulse stretcher

This block rebuilds a UART receive line from the pulse train of an infrared receiver. A short active-low pulse on the receiver line marks a zero bit. The block synchronises the line into the master clock domain and finds each falling edge. It then drives the NRZ receive output low for exactly one bit period at the programmed rate, however long the incoming pulse lasted. The bit period is 32·N master clocks, where N is the divisor input.

An active-low activity indicator mirrors the stretched data, so a lamp lights for every zero bit. Zero bits that follow each other arrive as pulses one bit period apart. The timer accepts a new edge in the last quarter of its window and restarts there, so a run of zeros comes out as one unbroken low level. Edges earlier in the window are treated as noise and ignored. The UART, the baud programming and any echo gating sit outside the block.

Top module: `irda_rx_stretch`

## Requirements
- R1: The receiver line passes through two synchroniser flops. When the line is first sampled low at a clock edge, the NRZ output goes low after the third clock edge counted from that edge.
- R2: The activity indicator `rxLedN` always equals `rxdOut`.
- R3: A falling edge seen while the output is high drives the output low for exactly 32·N master clocks.
- R4: The length of the incoming low pulse has no effect on the output. A two-clock pulse and a pulse longer than the whole window give the same low time.
- R5: The output returns high only when the window timer has run to its last count.
- R6: A falling edge is ignored when it is seen after fewer than 24·N clocks of the current window. The output still returns high at the end of the original window.
- R7: A falling edge seen after 24·N or more clocks of the window, up to and including its last clock, restarts the window. The output stays low without a break until 32·N clocks after the restart.
- R8: The divisor is captured when a window starts or restarts. A change during a window affects only later windows.
- R9: A divisor of 0 is treated as 1.
- R10: While `rst` is high the output is held high and the receiver line is ignored. A line that is still low when reset is released is not taken as a pulse; the line must go high and fall again first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Asynchronous reset, active high |
| irRxN | input | 1 | Pulse line from the infrared receiver, active low |
| divisor | input | DIV_W | Rate divisor N; the bit period is 32·N clocks |
| rxdOut | output | 1 | NRZ receive line towards the UART, idles high |
| rxLedN | output | 1 | Receive activity indicator, active low |

## Verification
Two things can happen in the same cycle: the window reaches its last count, and a new falling edge arrives that must restart it. The bench provokes this by placing the second pulse exactly 32·N clocks after the first. The output must then stay low for 64·N clocks with no high cycle in between. The edges of the late zone are probed with second pulses placed 24·N and 24·N+1 clocks after the first. The first must leave the window unchanged and the second must extend it.

// File: rtl/irda_rx_pkg.sv
`timescale 1ns/1ps
package irda_rx_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWin;   // clear the timer and capture the divisor
    logic countEn;   // advance the timer
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic fallSeen;  // synchronised falling edge on the receiver line
    logic lateZone;  // timer is in the last quarter of the window
    logic atEnd;     // timer is on the last clock of the window
  } dp_status_t;

endpackage

// File: rtl/irda_rx_datapath.sv
`timescale 1ns/1ps
module irda_rx_datapath
  import irda_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irRxN,
  input  logic [DIV_W-1:0] divisor,
  input  ctrl_strobe_t     strobe,
  output dp_status_t       status
);
  localparam int CNT_W = DIV_W + 5;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic [DIV_W-1:0]       nEff;
  logic [CNT_W-1:0]       winLen;
  logic [CNT_W-1:0]       elapsed;
  logic [CNT_W-1:0]       lateStart;

  // Synchroniser chain; resets low so a line held low across reset
  // shows no falling edge.
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) syncQ[gi] <= 1'b0;
          else     syncQ[gi] <= irRxN;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) syncQ[gi] <= 1'b0;
          else     syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prevLvl <= 1'b0;
    else     prevLvl <= syncQ[LAST];
  end

  assign nEff = (divisor == '0) ? DIV_W'(1) : divisor;

  // Window timer
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      winLen  <= CNT_W'(32);
      elapsed <= '0;
    end else if (strobe.loadWin) begin
      winLen  <= {nEff, 5'b0};
      elapsed <= '0;
    end else if (strobe.countEn) begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  assign lateStart       = winLen - (winLen >> 2);
  assign status.fallSeen = prevLvl & ~syncQ[LAST];
  assign status.lateZone = (elapsed >= lateStart);
  assign status.atEnd    = (elapsed == winLen - CNT_W'(1));

endmodule

// File: rtl/irda_rx_control.sv
`timescale 1ns/1ps
module irda_rx_control
  import irda_rx_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         rxActive
);
  logic startNow;
  logic activeNext;

  always_comb begin
    // start from idle, or restart in the late quarter; a restart
    // wins over the window end falling in the same cycle
    startNow = status.fallSeen & (~rxActive | status.lateZone);
    if (startNow)                      activeNext = 1'b1;
    else if (rxActive && status.atEnd) activeNext = 1'b0;
    else                               activeNext = rxActive;
    strobe.loadWin = startNow;
    strobe.countEn = rxActive;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rxActive <= 1'b0;
    else     rxActive <= activeNext;
  end

endmodule

// File: rtl/irda_rx_stretch.sv
`timescale 1ns/1ps
module irda_rx_stretch
  import irda_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irRxN,
  input  logic [DIV_W-1:0] divisor,
  output logic             rxdOut,
  output logic             rxLedN
);
  ctrl_strobe_t strobe;
  dp_status_t   dpStatus;
  logic         rxActive;
  logic         fallSeen;
  logic         atEnd;

  irda_rx_datapath #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .irRxN(irRxN), .divisor(divisor),
    .strobe(strobe), .status(dpStatus)
  );

  irda_rx_control u_ctl (
    .clk(clk), .rst(rst), .status(dpStatus),
    .strobe(strobe), .rxActive(rxActive)
  );

  assign fallSeen = dpStatus.fallSeen;
  assign atEnd    = dpStatus.atEnd;
  assign rxdOut   = ~rxActive;
  assign rxLedN   = ~rxActive;

endmodule

// File: rtl/irda_rx_stretch_checker.sv
`timescale 1ns/1ps
module irda_rx_stretch_checker (
  input logic clk,
  input logic rst,
  input logic rxdOut,
  input logic fallSeen,
  input logic atEnd
);
  // R3: a detected edge always leaves the output low on the next cycle
  a_r3_fall_drives_low: assert property (@(posedge clk) disable iff (rst)
    fallSeen |=> !rxdOut);

  // R3: a window is never a single clock long
  a_r3_min_low: assert property (@(posedge clk) disable iff (rst)
    $fell(rxdOut) |=> !rxdOut);

  // R5: output rises only after the timer reached its last count
  a_r5_rise_needs_end: assert property (@(posedge clk) disable iff (rst)
    $rose(rxdOut) |-> $past(atEnd));

  // R10: output is idle high on the first cycle after reset release
  a_r10_release_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rxdOut);
endmodule

bind irda_rx_stretch irda_rx_stretch_checker u_chk (
  .clk(clk), .rst(rst), .rxdOut(rxdOut), .fallSeen(fallSeen), .atEnd(atEnd)
);

// File: tb/irda_rx_stretch_bench.sv
`timescale 1ns/1ps
module irda_rx_stretch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             irRxN = 1'b1;
  logic [DIV_W-1:0] divisor = DIV_W'(1);
  logic             rxdOut;
  logic             rxLedN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irda_rx_stretch #(.DIV_W(DIV_W)) u_irda_rx_stretch (
    .clk(clk), .rst(rst), .irRxN(irRxN), .divisor(divisor),
    .rxdOut(rxdOut), .rxLedN(rxLedN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // schedule a low pulse starting `at` negedges from now, lasting w negedges
  task automatic schedPulse(int at, int w);
    fork
      begin
        repeat (at) @(negedge clk);
        irRxN = 1'b0;
        repeat (w) @(negedge clk);
        irRxN = 1'b1;
      end
    join_none
  endtask

  // called on the negedge where the first pulse starts
  task automatic measure(output int dly, output int lowLen, output int ledBad);
    dly = 0; lowLen = 0; ledBad = 0;
    while (rxdOut && dly < 20) begin
      @(negedge clk); dly++;
      if (rxLedN !== rxdOut) ledBad++;
    end
    while (!rxdOut && lowLen < 5000) begin
      @(negedge clk); lowLen++;
      if (rxLedN !== rxdOut) ledBad++;
    end
  endtask

  task automatic quiet(string req, int n);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!rxdOut) lows++;
    end
    chk(req, "output stays high afterwards", lows, 0);
  endtask

  task automatic runCase(string req, string what, int n, int w,
                         int k2, int k3, int expLow);
    int dly, lowLen, ledBad;
    divisor = DIV_W'(n);
    @(negedge clk);
    schedPulse(0, w);
    if (k2 > 0) schedPulse(k2, 2);
    if (k3 > 0) schedPulse(k3, 2);
    measure(dly, lowLen, ledBad);
    chk("R1", {what, " latency"}, dly, 3);
    chk(req, {what, " low time"}, lowLen, expLow);
    chk("R2", {what, " indicator mirrors data"}, ledBad, 0);
    quiet(req, 40);
  endtask

  task automatic testReset();
    rst = 1'b1;
    irRxN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "output high in reset", int'(rxdOut), 1);
    chk("R2", "indicator high in reset", int'(rxLedN), 1);
    rst = 1'b0;
    quiet("R10", 12);
    irRxN = 1'b1;
    repeat (4) @(negedge clk);
    runCase("R10", "first pulse after reset", 1, 2, 0, 0, 32);
  endtask

  task automatic testDivisorChange();
    int dly, lowLen, ledBad;
    divisor = DIV_W'(1);
    @(negedge clk);
    schedPulse(0, 2);
    fork
      begin repeat (6) @(negedge clk); divisor = DIV_W'(3); end
    join_none
    measure(dly, lowLen, ledBad);
    chk("R8", "mid-window divisor change keeps window", lowLen, 32);
    quiet("R8", 10);
    runCase("R8", "next window uses new divisor", 3, 2, 0, 0, 96);
  endtask

  initial begin
    doReset();
    testReset();
    runCase("R3", "short pulse N=1", 1, 2, 0, 0, 32);
    runCase("R4", "long pulse N=1", 1, 20, 0, 0, 32);
    runCase("R4", "pulse longer than window", 1, 50, 0, 0, 32);
    runCase("R3", "short pulse N=2", 2, 2, 0, 0, 64);
    runCase("R9", "divisor zero", 0, 2, 0, 0, 32);
    runCase("R6", "early second edge ignored", 1, 2, 10, 0, 32);
    runCase("R6", "edge one clock before late zone", 1, 2, 24, 0, 32);
    runCase("R7", "edge at start of late zone", 1, 2, 25, 0, 57);
    runCase("R7", "edge on last window clock N=1", 1, 2, 32, 0, 64);
    runCase("R7", "three zeros in a row", 1, 2, 32, 64, 96);
    runCase("R7", "edge on last window clock N=2", 2, 2, 64, 0, 128);
    testDivisorChange();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule